// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns a stream of characters into an asynchronous serial line signal. Characters enter through a valid/ready write port and wait in a 16-entry first-in first-out store. The store reports how many characters it holds and raises a full flag. A frame engine takes the oldest character and sends it as one frame on `txd`. The line rests high between frames. A frame is one low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits.

The frame format comes from static configuration pins. These choose 7 or 8 data bits, parity on or off, even or odd parity, and one or two stop bits. Change them only while the transmitter is idle. Timing comes from the clock-enable pulse `os_tick`, which runs at 16 or 8 times the bit rate; `cfg_os8` tells the block which. A flow-control input, `cts_n`, is active low. While it is high, no new frame begins, but a frame already on the line runs to its end.

Back-pressure on the write port works as follows. A character is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the store is full. A character offered while `in_ready` is low is dropped: nothing is stored and the count does not change. The writer does not have to hold `in_valid` until it is accepted.

Top module: `uart_fifo_tx`

## Requirements
- R1: A character is stored when in_valid and in_ready are both high at a rising clock edge. in_ready is high whenever fewer than 16 characters are held.
- R2: fill_count equals the number of characters held, from 0 to 16. It changes by at most one per clock.
- R3: With 16 characters held, fifo_full is 1 and in_ready is 0. A write offered then is ignored, and fill_count stays 16.
- R4: Characters leave on the line in the order they were written.
- R5: A frame is one low start bit, then the data bits least significant first, then the stop bits. The line is high whenever no frame is being sent.
- R6: With cfg_seven_bits=1, only bits 0 to 6 of a character are sent. Bit 7 is dropped. With cfg_seven_bits=0, all 8 bits are sent.
- R7: With cfg_parity_en=1, a parity bit follows the data bits and covers only those bits. cfg_parity_odd=0 gives even parity and 1 gives odd parity. With cfg_parity_en=0, no parity bit is sent.
- R8: cfg_two_stop=0 gives one high stop bit and cfg_two_stop=1 gives two.
- R9: Each bit lasts 16 os_tick pulses when cfg_os8=0, and 8 pulses when cfg_os8=1. txd changes mid-frame only on a clock that sampled os_tick high.
- R10: While cts_n is high, no new frame starts and held characters stay stored. A frame already started when cts_n rises is completed.
- R11: After reset, txd=1, fill_count=0, fifo_full=0, in_ready=1 and tx_busy=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Write request on the character port |
| in_ready | output | 1 | Store can accept a character |
| in_data | input | 8 | Character to send |
| fill_count | output | 5 | Characters held (0 to 16) |
| fifo_full | output | 1 | Store holds 16 characters |
| cfg_seven_bits | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_parity_en | input | 1 | 1: append a parity bit |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| cfg_os8 | input | 1 | 1: os_tick is 8x the bit rate, 0: 16x |
| os_tick | input | 1 | Oversampling clock-enable pulse |
| cts_n | input | 1 | Clear to send, active low; high holds off new frames |
| txd | output | 1 | Serial line, idles high |
| tx_busy | output | 1 | A frame is being sent |

## Verification
The bench uses the default parameters: a 16-deep store, 8-bit characters and a 4-bit oversampling counter. With these defaults the full and overflow boundary is reached by holding `cts_n` high and writing 17 characters. The bench drives `os_tick` on every second clock and changes the format between traffic bursts. This covers both oversampling ratios, both data lengths, both stop counts, and parity off, even and odd. A scoreboard compares each frame decoded from `txd` with the character written. Raising `cts_n` in the middle of a frame shows that the frame completes and that the next frame waits.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic seven_bits;
    logic parity_en;
    logic parity_odd;
    logic two_stop;
    logic os8;
  } tx_cfg_t;

endpackage

// File: rtl/tx_char_fifo.sv
module tx_char_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int OS_W = 4,
  localparam logic [OS_W-1:0] LAST_FULL = {OS_W{1'b1}},
  localparam logic [OS_W-1:0] LAST_HALF = {1'b0, {(OS_W-1){1'b1}}}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic os_tick,
  input  logic half_rate,
  output logic bit_end
);

  logic [OS_W-1:0] os_cnt;
  logic [OS_W-1:0] last;

  assign last    = half_rate ? LAST_HALF : LAST_FULL;
  assign bit_end = !clear && os_tick && (os_cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          os_cnt <= '0;
    else if (clear)      os_cnt <= '0;
    else if (bit_end)    os_cnt <= '0;
    else if (os_tick)    os_cnt <= os_cnt + 1'b1;
  end

endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tx_cfg_t           cfg,
  input  logic              have_data,
  input  logic [DATA_W-1:0] head_data,
  input  logic              cts_n,
  input  logic              bit_end,
  output logic              take,
  output logic              timer_clear,
  output logic              txd,
  output logic              busy
);

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] masked;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  last_idx;
  logic              par_q;
  logic              stop2_q;
  logic              txd_q;

  assign take        = (state == ST_IDLE) && have_data && !cts_n;
  assign timer_clear = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign txd         = txd_q;
  assign last_idx    = cfg.seven_bits ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
  assign masked      = cfg.seven_bits ? {1'b0, head_data[DATA_W-2:0]} : head_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      txd_q   <= 1'b1;
      shreg   <= '0;
      bit_idx <= '0;
      par_q   <= 1'b0;
      stop2_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          txd_q <= 1'b1;
          if (take) begin
            state   <= ST_START;
            txd_q   <= 1'b0;
            shreg   <= masked;
            par_q   <= (^masked) ^ cfg.parity_odd;
            bit_idx <= '0;
            stop2_q <= 1'b0;
          end
        end
        ST_START: if (bit_end) begin
          state <= ST_DATA;
          txd_q <= shreg[0];
          shreg <= shreg >> 1;
        end
        ST_DATA: if (bit_end) begin
          if (bit_idx == last_idx) begin
            if (cfg.parity_en) begin
              state <= ST_PARITY;
              txd_q <= par_q;
            end else begin
              state <= ST_STOP;
              txd_q <= 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
            txd_q   <= shreg[0];
            shreg   <= shreg >> 1;
          end
        end
        ST_PARITY: if (bit_end) begin
          state <= ST_STOP;
          txd_q <= 1'b1;
        end
        ST_STOP: if (bit_end) begin
          if (cfg.two_stop && !stop2_q) stop2_q <= 1'b1;
          else                          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_fifo_tx.sv
module uart_fifo_tx
  import uart_tx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int OS_W   = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [CNT_W-1:0]  fill_count,
  output logic              fifo_full,
  input  logic              cfg_seven_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_os8,
  input  logic              os_tick,
  input  logic              cts_n,
  output logic              txd,
  output logic              tx_busy
);

  tx_cfg_t           cfg;
  logic [DATA_W-1:0] head_data;
  logic              empty;
  logic              take;
  logic              timer_clear;
  logic              bit_end;

  assign cfg = '{seven_bits: cfg_seven_bits, parity_en: cfg_parity_en,
                 parity_odd: cfg_parity_odd, two_stop: cfg_two_stop, os8: cfg_os8};
  assign in_ready = !fifo_full;

  tx_char_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid),
    .push_data (in_data),
    .pop       (take),
    .head_data (head_data),
    .count     (fill_count),
    .full      (fifo_full),
    .empty     (empty)
  );

  tx_bit_timer #(.OS_W(OS_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (timer_clear),
    .os_tick   (os_tick),
    .half_rate (cfg.os8),
    .bit_end   (bit_end)
  );

  tx_framer #(.DATA_W(DATA_W)) framer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .have_data   (!empty),
    .head_data   (head_data),
    .cts_n       (cts_n),
    .bit_end     (bit_end),
    .take        (take),
    .timer_clear (timer_clear),
    .txd         (txd),
    .busy        (tx_busy)
  );

endmodule

// File: rtl/uart_fifo_tx_chk.sv
module uart_fifo_tx_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CNT_W-1:0] fill_count,
  input logic             fifo_full,
  input logic             os_tick,
  input logic             cts_n,
  input logic             txd,
  input logic             tx_busy
);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CNT_W'(DEPTH));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == $past(fill_count)) || (fill_count == $past(fill_count) + 1'b1) ||
    (fill_count + 1'b1 == $past(fill_count)));

  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !in_ready);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && in_valid) |=> (fill_count <= $past(fill_count)));

  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  a_r9_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy) && !$past(os_tick)) |-> $stable(txd));

  a_r10_cts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && cts_n) |=> !tx_busy);

endmodule

bind uart_fifo_tx uart_fifo_tx_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .fill_count (fill_count),
  .fifo_full  (fifo_full),
  .os_tick    (os_tick),
  .cts_n      (cts_n),
  .txd        (txd),
  .tx_busy    (tx_busy)
);

// File: tb/uart_fifo_tx_tb_top.sv
module uart_fifo_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [4:0] fill_count;
  logic       fifo_full;
  logic       cfg_seven_bits = 1'b0;
  logic       cfg_parity_en = 1'b0;
  logic       cfg_parity_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_os8 = 1'b0;
  logic       os_tick = 1'b0;
  logic       cts_n = 1'b0;
  logic       txd;
  logic       tx_busy;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  uart_fifo_tx dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .fill_count(fill_count), .fifo_full(fifo_full),
    .cfg_seven_bits(cfg_seven_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_os8(cfg_os8), .os_tick(os_tick), .cts_n(cts_n), .txd(txd),
    .tx_busy(tx_busy)
  );

  // os_tick high on every second clock
  always @(negedge clk) begin
    cycles  <= cycles + 1;
    os_tick <= ~os_tick;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic send(input logic [7:0] d, output bit acc);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    acc      = in_ready;
    @(posedge clk);
    if (acc) exp_q.push_back(d);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: decodes frames from txd and compares with the scoreboard
  initial begin
    forever begin
      int bc;
      int nbits;
      bit pen, podd, two;
      logic [7:0] got, exp;
      logic par, stp;
      bit ok;
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        bc = cfg_os8 ? 16 : 32;
        nbits = cfg_seven_bits ? 7 : 8;
        pen = cfg_parity_en; podd = cfg_parity_odd; two = cfg_two_stop;
        ok = 1'b1;
        repeat (bc / 2 - 1) @(negedge clk);
        if (txd !== 1'b0) ok = 1'b0;
        got = 8'h00;
        for (int i = 0; i < nbits; i++) begin
          repeat (bc) @(negedge clk);
          got[i] = txd;
        end
        par = 1'b0;
        if (pen) begin
          repeat (bc) @(negedge clk);
          par = txd;
        end
        repeat (bc) @(negedge clk);
        stp = txd;
        if (two) begin
          repeat (bc) @(negedge clk);
          stp = stp & txd;
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected frame", got, 0);
        end else begin
          exp = exp_q.pop_front();
          if (nbits == 7) exp[7] = 1'b0;
          // R5 R6 data bits, R9 timing through sample positions
          check(ok && got == exp, "R5/R6/R9 frame data", got, exp);
          if (pen) check(par == ((^exp) ^ podd), "R7 parity bit", par, (^exp) ^ podd);
          check(stp === 1'b1, "R8 stop bits", stp, 1);
        end
      end
    end
  end

  task automatic drain();
    wait (fill_count == 0 && exp_q.size() == 0);
    wait (!tx_busy);
    repeat (100) @(negedge clk);
  endtask

  initial begin
    bit acc;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(txd === 1'b1, "R11 txd", txd, 1);
    check(fill_count === 5'd0, "R11 fill_count", fill_count, 0);
    check(in_ready === 1'b1 && fifo_full === 1'b0, "R11 ready/full", {in_ready, fifo_full}, 2);
    check(tx_busy === 1'b0, "R11 busy", tx_busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // 8 bits, no parity, 1 stop, 16x
    send(8'h55, acc); check(acc, "R1 accept", acc, 1);
    check(fill_count <= 5'd1, "R2 count after one", fill_count, 1);
    send(8'hA3, acc); send(8'h00, acc); send(8'hFF, acc);
    drain();

    // 7 bits, even parity, 2 stop, 8x
    cfg_seven_bits = 1'b1; cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0;
    cfg_two_stop = 1'b1; cfg_os8 = 1'b1;
    send(8'h7F, acc); send(8'h15, acc); send(8'hC8, acc);
    drain();

    // 8 bits, odd parity, 1 stop, 16x
    cfg_seven_bits = 1'b0; cfg_parity_odd = 1'b1; cfg_two_stop = 1'b0; cfg_os8 = 1'b0;
    send(8'h01, acc); send(8'h80, acc); send(8'h3C, acc);
    drain();

    // R10 hold-off and R3 full boundary, 8 bits no parity 2 stop 8x
    cfg_parity_en = 1'b0; cfg_two_stop = 1'b1; cfg_os8 = 1'b1;
    cts_n = 1'b1;
    for (int i = 0; i < 16; i++) send(8'(8'h10 + i * 7), acc);
    check(fill_count === 5'd16, "R2 count at 16", fill_count, 16);
    check(fifo_full === 1'b1 && in_ready === 1'b0, "R3 full flags", {fifo_full, in_ready}, 2);
    send(8'hEE, acc);
    check(!acc, "R3 write ignored when full", acc, 0);
    check(fill_count === 5'd16, "R3 count stays 16", fill_count, 16);
    repeat (300) @(negedge clk);
    check(txd === 1'b1 && tx_busy === 1'b0, "R10 no start while cts_n high", {txd, tx_busy}, 2);
    check(fill_count === 5'd16, "R10 data retained", fill_count, 16);
    cts_n = 1'b0;
    wait (tx_busy);
    @(negedge clk);
    cts_n = 1'b1;
    wait (!tx_busy);
    repeat (200) @(negedge clk);
    check(tx_busy === 1'b0 && txd === 1'b1, "R10 next frame held", {tx_busy, txd}, 1);
    check(fill_count === 5'd15, "R10 one frame completed", fill_count, 15);
    check(exp_q.size() == 15, "R10 frame seen by monitor", exp_q.size(), 15);
    cts_n = 1'b0;
    drain();
    check(fill_count === 5'd0 && exp_q.size() == 0, "R4 all drained in order", fill_count, 0);
    finish_run();
  end

endmodule